// File: doc/BRIEF.md
# March-Test Memory Self-Test Engine

This block runs a built-in self-test of a small bit-cell array, for example the mask and data words of a content-addressable filter. A control state machine drives an address generator and a data-background generator through a fixed six-element march sequence. It issues one write or one read strobe per clock on a simple synchronous memory port. Every word read back is folded into a 16-bit multiple-input signature register (MISR). When the sequence completes, the final signature appears on a parallel output and is compared against a known-good value.

The engine needs no seed. The signature register always restarts from a fixed value, so a fault-free array always gives the same signature, whatever the array held before. The run level input acts as an enable. If it is dropped before the sequence finishes, the engine freezes and holds the intermediate signature, which helps fault isolation. A fresh rising edge on the run input always restarts the test from the beginning.

The minimum run length is 10*DEPTH+2 clock edges, counted from the edge that sees the rising run input. It is available as the localparam `RUN_CYCLES`.

Top module: `march_bist`

## Requirements
- R1: While reset is active and right after it, done_o is 0, sig_o is 16'hFFFF, and neither mem_we_o nor mem_re_o is asserted.
- R2: The first clock edge at which run_i is 1 after having been 0 (re)starts the test. sig_o returns to 16'hFFFF and done_o to 0 at that edge, no strobe is issued in that cycle, and the march begins again from its first operation. No seed is loaded.
- R3: The operations follow six elements in order. (1) ascending: write 0. (2) ascending: read, write 1. (3) ascending: read, write 0. (4) descending: read, write 1. (5) descending: read, write 0. (6) ascending: read. Ascending means addresses 0..DEPTH-1 and descending means DEPTH-1..0. Write 0 and write 1 drive mem_wdata_o as all zeros and all ones. In the two-operation elements, the read and the write at one address occupy consecutive cycles.
- R4: mem_rdata_i is sampled on the clock edge one cycle after the edge that ends a cycle with mem_re_o high. Each sampled word d, zero-extended to 16 bits, updates the signature as s' = {s[14:0],0} ^ (s[15] ? 16'h1021 : 0) ^ d.
- R5: A full run issues exactly 5*DEPTH writes and 5*DEPTH reads. done_o rises exactly 10*DEPTH+2 clock edges after the edge that starts the run.
- R6: Once done_o is 1, done_o and sig_o hold, whether or not run_i stays high, until the next restart of R2.
- R7: When run_i is 0 during a run, no strobe is issued and done_o stays 0. After at most one final fold of a read already issued, sig_o holds the signature of all words read so far.
- R8: A fault-free array gives the same signature on every run, whatever its contents before the run.
- R9: A single bit cell stuck at 0 or at 1 gives a signature different from the fault-free one.
- R10: A bit cell that fails its 0-to-1 or its 1-to-0 transition gives a signature different from the fault-free one.
- R11: An up-transition coupling fault, where writing 0-to-1 into one bit flips another bit in the same or another word, gives a signature different from the fault-free one.
- R12: At most one of mem_we_o and mem_re_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run enable; a rising level restarts, a low level pauses |
| done_o | output | 1 | Sequence complete, signature final |
| sig_o | output | 16 | Current signature register value |
| mem_addr_o | output | $clog2(DEPTH) | Array word address |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_wdata_o | output | WIDTH | Write data (all zeros or all ones) |
| mem_rdata_i | input | WIDTH | Read data, valid one cycle after mem_re_o |

## Verification
The hardest conditions to reach from the ports are the fault cases. A healthy array never shows a stuck, sluggish or coupled cell. The bench therefore uses a behavioural array that can inject one of these faults. It sweeps a stuck-at-0 and a stuck-at-1 fault over every bit of every word, and places transition and coupling faults so that aggressors lie above, below and inside the victim's word. The paused state is also hard to reach. The bench drops run_i in the middle of a read-then-write element, so a read is still waiting to be folded, and compares the frozen signature with its own fold of the words it returned.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

   localparam int          SIG_W     = 16;
   localparam logic [15:0] MISR_POLY = 16'h1021;
   localparam logic [15:0] MISR_INIT = 16'hFFFF;
   localparam int          N_ELEM    = 6;
   localparam int          OPS_PER_WORD = 10;   // total strobes per address in the whole march

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_FLUSH,
      ST_DONE
   } bist_state_e;

   // one issued operation
   typedef struct packed {
      logic wr;     // write strobe
      logic rd;     // read strobe
      logic down;   // descending address order
      logic bg;     // background value written
   } march_op_t;

   function automatic logic [SIG_W-1:0] misr_step(logic [SIG_W-1:0] s, logic [SIG_W-1:0] d);
      return {s[SIG_W-2:0], 1'b0} ^ (s[SIG_W-1] ? MISR_POLY : '0) ^ d;
   endfunction

endpackage

// File: rtl/march_seq_ctrl.sv
module march_seq_ctrl
   import march_bist_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run_i,
   output logic                     start_o,
   output march_op_t                op_o,
   output logic [$clog2(DEPTH)-1:0] idx_o,
   output logic                     done_o
);
   localparam int IW = $clog2(DEPTH);
   localparam logic [2:0] LAST_ELEM = 3'(N_ELEM - 1);

   bist_state_e   state_q;
   logic [2:0]    elem_q;
   logic [IW-1:0] idx_q;
   logic          phase_q;
   logic          run_q;

   logic start, active, single, is_read, last_idx;

   always_comb begin
      start    = run_i & ~run_q;
      active   = (state_q == ST_RUN) & run_i & ~start;
      single   = (elem_q == 3'd0) | (elem_q == LAST_ELEM);
      is_read  = (elem_q == LAST_ELEM) | (~single & ~phase_q);
      last_idx = (idx_q == IW'(DEPTH - 1));
      op_o.wr   = active & ~is_read;
      op_o.rd   = active & is_read;
      op_o.down = (elem_q == 3'd3) | (elem_q == 3'd4);
      op_o.bg   = elem_q[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         state_q <= ST_IDLE;
         elem_q  <= '0;
         idx_q   <= '0;
         phase_q <= 1'b0;
      end else begin
         run_q <= run_i;
         if (start) begin
            state_q <= ST_RUN;
            elem_q  <= '0;
            idx_q   <= '0;
            phase_q <= 1'b0;
         end else begin
            case (state_q)
               ST_RUN: begin
                  if (run_i) begin
                     if (single || phase_q) begin
                        phase_q <= 1'b0;
                        if (last_idx) begin
                           idx_q <= '0;
                           if (elem_q == LAST_ELEM) state_q <= ST_FLUSH;
                           else                     elem_q  <= elem_q + 3'd1;
                        end else begin
                           idx_q <= idx_q + IW'(1);
                        end
                     end else begin
                        phase_q <= 1'b1;
                     end
                  end
               end
               ST_FLUSH: state_q <= ST_DONE;
               default: ;
            endcase
         end
      end
   end

   assign start_o = start;
   assign idx_o   = idx_q;
   assign done_o  = (state_q == ST_DONE);

endmodule

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
   parameter int DEPTH = 16
) (
   input  logic [$clog2(DEPTH)-1:0] idx_i,
   input  logic                     down_i,
   output logic [$clog2(DEPTH)-1:0] addr_o
);
   localparam int  AW      = $clog2(DEPTH);
   localparam bit  POW2    = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (POW2) begin : g_pow2
         // reverse order is a plain bit inversion
         assign addr_o = down_i ? ~idx_i : idx_i;
      end else begin : g_any
         assign addr_o = down_i ? (AW'(DEPTH - 1) - idx_i) : idx_i;
      end
   endgenerate

endmodule

// File: rtl/march_data_gen.sv
module march_data_gen #(
   parameter int WIDTH = 8
) (
   input  logic             bg_i,
   output logic [WIDTH-1:0] wdata_o
);
   assign wdata_o = {WIDTH{bg_i}};
endmodule

// File: rtl/march_misr.sv
module march_misr
   import march_bist_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             en_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [SIG_W-1:0] sig_o
);
   logic [SIG_W-1:0] data_ext;
   logic [SIG_W-1:0] sig_q;

   generate
      if (WIDTH == SIG_W) begin : g_full
         assign data_ext = data_i;
      end else begin : g_pad
         assign data_ext = {{(SIG_W - WIDTH){1'b0}}, data_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sig_q <= MISR_INIT;
      else if (clear_i) sig_q <= MISR_INIT;
      else if (en_i)    sig_q <= misr_step(sig_q, data_ext);
   end

   assign sig_o = sig_q;

endmodule

// File: rtl/march_bist.sv
module march_bist
   import march_bist_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run_i,
   output logic                     done_o,
   output logic [15:0]              sig_o,
   output logic [$clog2(DEPTH)-1:0] mem_addr_o,
   output logic                     mem_we_o,
   output logic                     mem_re_o,
   output logic [WIDTH-1:0]         mem_wdata_o,
   input  logic [WIDTH-1:0]         mem_rdata_i
);
   localparam int AW         = $clog2(DEPTH);
   localparam int RUN_CYCLES = OPS_PER_WORD * DEPTH + 2;   // start edge .. done visible

   initial begin
      assert (DEPTH >= 2) else $error("march_bist: DEPTH must be at least 2");
      assert (WIDTH >= 1 && WIDTH <= SIG_W) else $error("march_bist: WIDTH must be 1..16");
      assert (RUN_CYCLES > 0) else $error("march_bist: bad run length");
   end

   logic          start;
   march_op_t     op;
   logic [AW-1:0] idx;
   logic          capture_q;

   march_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run_i),
      .start_o (start),
      .op_o    (op),
      .idx_o   (idx),
      .done_o  (done_o)
   );

   march_addr_gen #(.DEPTH(DEPTH)) u_addr (
      .idx_i  (idx),
      .down_i (op.down),
      .addr_o (mem_addr_o)
   );

   march_data_gen #(.WIDTH(WIDTH)) u_data (
      .bg_i    (op.bg),
      .wdata_o (mem_wdata_o)
   );

   // read data arrives one cycle after the strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     capture_q <= 1'b0;
      else if (start) capture_q <= 1'b0;
      else            capture_q <= op.rd;
   end

   march_misr #(.WIDTH(WIDTH)) u_misr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start),
      .en_i    (capture_q),
      .data_i  (mem_rdata_i),
      .sig_o   (sig_o)
   );

   assign mem_we_o = op.wr;
   assign mem_re_o = op.rd;

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        run_i,
   input logic        done_o,
   input logic [15:0] sig_o,
   input logic        mem_we_o,
   input logic        mem_re_o
);

   p_single_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && mem_re_o));

   p_strobe_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o || mem_re_o) |-> run_i);

   p_paused_sig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run_i) && !$past(run_i, 2)) |-> $stable(sig_o));

   p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_i) && !$past(run_i, 2)) |-> (sig_o == 16'hFFFF && !done_o));

   p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done_o) && !done_o) |-> ($past(run_i) && !$past(run_i, 2)));

   p_done_sig_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done_o) && done_o) |-> $stable(sig_o));

endmodule

bind march_bist march_bist_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_i    (run_i),
   .done_o   (done_o),
   .sig_o    (sig_o),
   .mem_we_o (mem_we_o),
   .mem_re_o (mem_re_o)
);

// File: tb/march_bist_tb_top.sv
module march_bist_tb_top;
   localparam int DEPTH   = 16;
   localparam int WIDTH   = 8;
   localparam int AW      = $clog2(DEPTH);
   localparam int EXP_CYC = 10 * DEPTH + 2;
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             run_i = 1'b0;
   logic             done;
   logic [15:0]      sig;
   logic [AW-1:0]    addr;
   logic             we, re;
   logic [WIDTH-1:0] wdata;
   logic [WIDTH-1:0] rdata = '0;

   always #4 clk = ~clk;   // 8-unit period, 125 MHz with 1 ns units

   march_bist #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .done_o(done), .sig_o(sig),
      .mem_addr_o(addr), .mem_we_o(we), .mem_re_o(re),
      .mem_wdata_o(wdata), .mem_rdata_i(rdata)
   );

   int checks = 0, fails = 0;
   bit finished = 0;

   // behavioural array with fault injection
   // kind: 0 none, 1 stuck-at, 2 no 0->1, 3 no 1->0, 4 up-coupling aggressor->victim
   logic [WIDTH-1:0] arr [DEPTH];
   int f_kind = 0, f_addr = 0, f_bit = 0, f_val = 0, v_addr = 0, v_bit = 0;

   always @(posedge clk) begin : mem_model
      logic [WIDTH-1:0] rv, old, nw;
      if (re) begin
         rv = arr[addr];
         if (f_kind == 1 && int'(addr) == f_addr) rv[f_bit] = f_val[0];
         rdata <= rv;
      end
      if (we) begin
         old = arr[addr];
         nw  = wdata;
         if (f_kind == 2 && int'(addr) == f_addr && !old[f_bit] && nw[f_bit]) nw[f_bit] = 1'b0;
         if (f_kind == 3 && int'(addr) == f_addr && old[f_bit] && !nw[f_bit]) nw[f_bit] = 1'b1;
         arr[addr] = nw;
         if (f_kind == 4 && int'(addr) == f_addr && !old[f_bit] && nw[f_bit])
            arr[v_addr][v_bit] = ~arr[v_addr][v_bit];
      end
   end

   function automatic logic [15:0] step(logic [15:0] s, logic [WIDTH-1:0] d);
      logic [15:0] t;
      t = {s[14:0], 1'b0};
      if (s[15]) t = t ^ 16'h1021;
      return t ^ 16'(d);
   endfunction

   function automatic logic [15:0] golden();
      logic [15:0] s = 16'hFFFF;
      for (int p = 0; p < 5; p++)
         for (int i = 0; i < DEPTH; i++)
            s = step(s, (p % 2 == 1) ? ONES : '0);
      return s;
   endfunction

   // expected k-th operation of the march
   function automatic void exp_op(int k, output int a, output bit w, output bit v);
      int j, e, r, ix;
      if (k < DEPTH) begin
         a = k; w = 1; v = 0;
      end else if (k < 9 * DEPTH) begin
         j  = k - DEPTH;
         e  = 1 + j / (2 * DEPTH);
         r  = j % (2 * DEPTH);
         ix = r / 2;
         w  = (r % 2) == 1;
         v  = (e % 2) == 1;
         a  = (e >= 3) ? (DEPTH - 1 - ix) : ix;
      end else begin
         a = k - 9 * DEPTH; w = 0; v = 0;
      end
   endfunction

   // port monitor and independent signature fold
   logic [15:0] model = 16'hFFFF;
   bit pend = 0;
   int k_op = 0, seq_err = 0, wr_cnt = 0, rd_cnt = 0, strobe_idle = 0;

   always @(negedge clk) begin : monitor
      int ea; bit ew, ev;
      if (pend) model = step(model, rdata);
      pend = re;
      if (we || re) begin
         if (!run_i) strobe_idle++;
         exp_op(k_op, ea, ew, ev);
         if (int'(addr) != ea || we != ew || (we && wdata != (ev ? ONES : '0))) seq_err++;
         if (we) wr_cnt++; else rd_cnt++;
         k_op++;
      end
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic begin_run();
      @(negedge clk);
      run_i   = 1'b1;
      model   = 16'hFFFF;
      pend    = 0;
      k_op    = 0; seq_err = 0; wr_cnt = 0; rd_cnt = 0;
   endtask

   task automatic run_full(output int cyc);
      begin_run();
      cyc = 0;
      do begin
         @(posedge clk); cyc++;
         @(negedge clk);
      end while (!done && cyc < 4000);
   endtask

   task automatic stop_run();
      run_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic fault_run(string req, string what);
      int c;
      run_full(c);
      chk(done && sig != golden(), req, what, sig, golden());
      stop_run();
      f_kind = 0;
   endtask

   initial begin
      int cyc;
      logic [15:0] held;
      for (int i = 0; i < DEPTH; i++) arr[i] = '0;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!done && sig == 16'hFFFF && !we && !re, "R1", "reset outputs", {done, sig, we, re}, 19'h0FFFF << 2);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!done && sig == 16'hFFFF, "R1", "after reset", sig, 16'hFFFF);

      // full fault-free run
      run_full(cyc);
      chk(cyc == EXP_CYC, "R5", "cycles to done", cyc, EXP_CYC);
      chk(wr_cnt == 5 * DEPTH, "R5", "write count", wr_cnt, 5 * DEPTH);
      chk(rd_cnt == 5 * DEPTH, "R5", "read count", rd_cnt, 5 * DEPTH);
      chk(seq_err == 0 && k_op == 10 * DEPTH, "R3", "operation order mismatches", seq_err, 0);
      chk(sig == golden(), "R4", "golden signature", sig, golden());
      chk(sig == model, "R4", "signature vs port fold", sig, model);

      // R6: hold after completion
      held = sig;
      repeat (10) @(negedge clk);
      chk(done && sig == held, "R6", "hold with run high", sig, held);
      run_i = 1'b0;
      repeat (6) @(negedge clk);
      chk(done && sig == held, "R6", "hold with run low", sig, held);

      // R2: restart clears; R7: pause mid-element
      begin_run();
      @(negedge clk);
      chk(!done && sig == 16'hFFFF, "R2", "restart clears signature", sig, 16'hFFFF);
      repeat (DEPTH + 7) @(negedge clk);
      run_i = 1'b0;
      strobe_idle = 0;
      repeat (2) @(negedge clk);
      held = sig;
      repeat (20) @(negedge clk);
      chk(sig == held && !done, "R7", "paused signature held", sig, held);
      chk(strobe_idle == 0, "R7", "strobes while paused", strobe_idle, 0);
      chk(sig == model && k_op > DEPTH, "R7", "partial signature", sig, model);

      // R2: restart after pause begins from first operation
      run_full(cyc);
      chk(seq_err == 0 && cyc == EXP_CYC, "R2", "restart sequence errors", seq_err, 0);
      chk(sig == golden(), "R2", "restart signature", sig, golden());
      stop_run();

      // R8: different prior contents, same signature
      for (int i = 0; i < DEPTH; i++) arr[i] = WIDTH'(i * 37 + 5);
      run_full(cyc);
      chk(sig == golden(), "R8", "prefilled array", sig, golden());
      stop_run();
      for (int i = 0; i < DEPTH; i++) arr[i] = ~WIDTH'(i * 11);
      run_full(cyc);
      chk(sig == golden(), "R8", "second prefill", sig, golden());
      stop_run();

      // R9: stuck-at sweep over every cell
      for (int a = 0; a < DEPTH; a++)
         for (int b = 0; b < WIDTH; b++)
            for (int v = 0; v < 2; v++) begin
               f_kind = 1; f_addr = a; f_bit = b; f_val = v;
               fault_run("R9", $sformatf("stuck-at-%0d a%0d b%0d", v, a, b));
            end

      // R10: transition faults
      for (int a = 0; a < DEPTH; a += 5)
         for (int t = 2; t <= 3; t++) begin
            f_kind = t; f_addr = a; f_bit = a % WIDTH;
            fault_run("R10", $sformatf("transition kind%0d a%0d", t, a));
         end

      // R11: coupling, aggressor above, below, same word
      f_kind = 4; f_addr = 3;  f_bit = 2; v_addr = 9; v_bit = 5;
      fault_run("R11", "coupling low->high");
      f_kind = 4; f_addr = 12; f_bit = 0; v_addr = 1; v_bit = 7;
      fault_run("R11", "coupling high->low");
      f_kind = 4; f_addr = 5;  f_bit = 4; v_addr = 5; v_bit = 1;
      fault_run("R11", "coupling same word");

      // R12 covered by property p_single_op_r12; confirm again fault-free
      run_full(cyc);
      chk(sig == golden(), "R12", "final clean run", sig, golden());
      stop_run();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule